// File: doc/BRIEF.md
# Serial Stereo Audio Transmitter (Bus Slave)

This block sends 16-bit stereo audio on an I2S bus where another device is the clock master. The master drives the bit clock and the word-select line. The block oversamples both lines with its own system clock, so all of its logic stays in one clock domain. Sample pairs arrive on a ready/valid handshake and wait in a one-entry holding register. A pair is taken when a left slot begins. Its left half is shifted out MSB first during the left slot, and its right half during the following right slot.

A static configuration input selects the slot width. Narrow slots carry 16 bits, which gives a 32-bit frame with the bit clock at 32 × Fs (about 1.41 MHz at 44.1 kHz). Wide slots carry 32 bits, which gives a 64-bit frame with the bit clock at 64 × Fs (2.8224 MHz at 44.1 kHz). In a wide slot the sample fills the upper 16 bits and the lower 16 bits are zero.

The block counts bit clocks between word-select transitions. If the count does not match the configured slot width, it raises a sticky flag. This catches a master that is clocked for the other frame size, which would otherwise leave the channels misaligned. If no pair is waiting when a frame starts, the block sends silence in both slots and raises a sticky underrun flag.

Top module: `i2s_slave_tx`

## Requirements
- R1: A low word-select level carries the left sample and a high level carries the right sample. Each frame sends the left slot of a pair and then the right slot of the same pair.
- R2: The first bit of a slot is driven on the first falling bit-clock edge after the rising edge at which a word-select change is seen. The master therefore samples the MSB one bit clock after the word-select edge. Bits are sent MSB first.
- R3: With `slot_wide` = 0, each slot is 16 bits and holds exactly the 16-bit sample.
- R4: With `slot_wide` = 1, each slot is 32 bits. Slot bits 31..16 hold the sample and slot bits 15..0 are zero.
- R5: `sdata` changes only right after a falling bit-clock edge has been detected, so it is stable around each rising edge.
- R6: `in_ready` is high exactly when the holding register is empty. A pair is accepted on a clock edge where `in_valid` and `in_ready` are both high. The held pair is consumed when the next left slot is loaded.
- R7: If the holding register is empty when a left slot is loaded, both slots of that frame are all zeros and `underrun` becomes 1. It then stays 1 until reset.
- R8: `mismatch` becomes 1 when the number of rising bit-clock edges between two consecutive word-select transitions differs from the configured slot width, and it stays 1 until reset. The partial phase before the first transition after reset is not judged. Matching clocks never set the flag.
- R9: After reset, `sdata` is 0, `in_ready` is 1, and `underrun` and `mismatch` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_wide | input | 1 | Slot width select: 0 = 16-bit slots, 1 = 32-bit slots (static) |
| bclk | input | 1 | Bit clock from the bus master |
| lrclk | input | 1 | Word select from the bus master: 0 = left, 1 = right |
| in_valid | input | 1 | A sample pair is offered |
| in_ready | output | 1 | The holding register can take a pair |
| in_left | input | 16 | Left sample, two's complement |
| in_right | input | 16 | Right sample, two's complement |
| sdata | output | 1 | Serial data to the bus |
| underrun | output | 1 | Sticky: a frame started with no pair waiting |
| mismatch | output | 1 | Sticky: bit-clock count per phase differed from the slot width |

## Verification
The assertions assume that each level of `bclk` lasts at least four system clocks. They also assume that `lrclk` changes only while `bclk` is low, and that `slot_wide` is changed only under reset. The stimulus generates the bus clocks with a half period of eight system clocks and moves word-select together with the falling bit clock. It changes the slot width only between resets. The master model in the bench captures `sdata` on each rising bit-clock edge, the way a receiver would. Deliberate underruns and wrong-sized phases are driven on the same legal clock timing.

// File: rtl/i2s_slave_tx.sv
module i2s_slave_tx #(
  parameter int SAMPLE_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slot_wide,
  input  logic                bclk,
  input  logic                lrclk,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                sdata,
  output logic                underrun,
  output logic                mismatch
);
  localparam int WIDE_W = 2 * SAMPLE_W;
  localparam int CNT_W  = $clog2(4 * WIDE_W);
  localparam logic [CNT_W-1:0] CNT_MAX    = '1;
  localparam logic [CNT_W-1:0] LEN_NARROW = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] LEN_WIDE   = CNT_W'(WIDE_W);

  logic [SYNC_STAGES-1:0] bclk_sync, ws_sync;
  logic                   bclk_d;
  logic                   bclk_s, ws_s, rise_ev, fall_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_sync <= '1;
      ws_sync   <= '1;
      bclk_d    <= 1'b1;
    end else begin
      bclk_sync <= {bclk_sync[SYNC_STAGES-2:0], bclk};
      ws_sync   <= {ws_sync[SYNC_STAGES-2:0], lrclk};
      bclk_d    <= bclk_s;
    end
  end

  assign bclk_s  = bclk_sync[SYNC_STAGES-1];
  assign ws_s    = ws_sync[SYNC_STAGES-1];
  assign rise_ev = bclk_s & ~bclk_d;
  assign fall_ev = ~bclk_s & bclk_d;

  logic             ws_cur, seen, pend, pend_ch;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] slot_len;

  assign slot_len = slot_wide ? LEN_WIDE : LEN_NARROW;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_cur   <= 1'b1;
      seen     <= 1'b0;
      pend     <= 1'b0;
      pend_ch  <= 1'b0;
      cnt      <= '0;
      mismatch <= 1'b0;
    end else if (rise_ev) begin
      ws_cur <= ws_s;
      if (ws_s != ws_cur) begin
        pend    <= 1'b1;
        pend_ch <= ws_s;
        seen    <= 1'b1;
        cnt     <= CNT_W'(1);
        if (seen && cnt != slot_len) mismatch <= 1'b1;
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end else if (fall_ev) begin
      pend <= 1'b0;
    end
  end

  logic                hold_v;
  logic [SAMPLE_W-1:0] hold_l, hold_r, right_tx;
  logic [WIDE_W-1:0]   sr, load_word;
  logic                accept, pop, load;

  assign in_ready = ~hold_v;
  assign accept   = in_valid & ~hold_v;
  assign load     = fall_ev & pend;
  assign pop      = load & ~pend_ch & hold_v;

  always_comb begin
    if (pend_ch) load_word = {right_tx, {SAMPLE_W{1'b0}}};
    else if (hold_v) load_word = {hold_l, {SAMPLE_W{1'b0}}};
    else load_word = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v   <= 1'b0;
      hold_l   <= '0;
      hold_r   <= '0;
      right_tx <= '0;
      sr       <= '0;
      sdata    <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (accept) begin
        hold_v <= 1'b1;
        hold_l <= in_left;
        hold_r <= in_right;
      end else if (pop) begin
        hold_v <= 1'b0;
      end
      if (load) begin
        sdata <= load_word[WIDE_W-1];
        sr    <= {load_word[WIDE_W-2:0], 1'b0};
        if (!pend_ch) begin
          right_tx <= hold_v ? hold_r : '0;
          if (!hold_v) underrun <= 1'b1;
        end
      end else if (fall_ev) begin
        sdata <= sr[WIDE_W-1];
        sr    <= {sr[WIDE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/i2s_slave_tx_chk.sv
module i2s_slave_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic sdata,
  input logic fall_ev,
  input logic rise_ev,
  input logic pop,
  input logic in_valid,
  input logic in_ready,
  input logic underrun,
  input logic mismatch
);
  assert_sdata_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $past(fall_ev));

  assert_accept_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_ready_after_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(pop));

  assert_underrun_at_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(fall_ev));

  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  assert_mismatch_at_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mismatch) |-> $past(rise_ev));

  assert_mismatch_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> mismatch);
endmodule

bind i2s_slave_tx i2s_slave_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sdata(sdata), .fall_ev(fall_ev), .rise_ev(rise_ev),
  .pop(pop), .in_valid(in_valid), .in_ready(in_ready),
  .underrun(underrun), .mismatch(mismatch)
);

// File: tb/i2s_slave_tx_tb_top.sv
`timescale 1ns/1ps
module i2s_slave_tx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_wide = 1'b0;
  logic bclk = 1'b1;
  logic lrclk = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_left = '0;
  logic [15:0] in_right = '0;
  logic sdata, underrun, mismatch;

  always #2.5 clk = ~clk;

  i2s_slave_tx dut_i (
    .clk(clk), .rst_n(rst_n), .slot_wide(slot_wide), .bclk(bclk), .lrclk(lrclk),
    .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
    .sdata(sdata), .underrun(underrun), .mismatch(mismatch)
  );

  int checks = 0;
  int errors = 0;
  bit feed = 1'b0;
  logic [31:0] q[$];
  logic [15:0] cur_l = 16'h8001;
  logic [15:0] cur_r = 16'h7FFE;
  logic [31:0] acc = '0;
  logic [15:0] exp_l, exp_r;
  bit exp_ok = 1'b0;
  bit r_pend = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: offers pairs whenever feeding, records accepted pairs in the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      in_valid = feed;
      in_left  = cur_l;
      in_right = cur_r;
      if (feed && in_ready) begin
        q.push_back({cur_l, cur_r});
        cur_l = cur_l * 16'h6255 + 16'h3619;
        cur_r = {cur_r[14:0], cur_r[15] ^ cur_r[13] ^ cur_r[12] ^ cur_r[10]} + 16'h0101;
      end
    end
  end

  function automatic logic [31:0] slot_word(input logic [15:0] s, input int w);
    return (w == 32) ? {s, 16'h0000} : {16'h0000, s};
  endfunction

  function automatic logic [31:0] window(input int w);
    return (w == 32) ? acc : {16'h0000, acc[15:0]};
  endfunction

  // master model: drives clocks, captures on rising edges, scores slots
  task automatic run_frame(input int bits, input bit chk, input int cfgw);
    string tag;
    tag = (cfgw == 32) ? "R4" : "R3";
    for (int ch = 0; ch < 2; ch++) begin
      for (int b = 0; b < bits; b++) begin
        bclk = 1'b0;
        if (b == 0) lrclk = ch[0];
        repeat (8) @(negedge clk);
        acc = {acc[30:0], sdata};
        bclk = 1'b1;
        if (chk && b == 0) begin
          if (ch == 1 && exp_ok) begin
            check({"R1 R2 ", tag, " left slot"}, window(cfgw), slot_word(exp_l, cfgw));
            r_pend = 1'b1;
          end
          if (ch == 0 && r_pend) begin
            check({"R1 R2 ", tag, " right slot"}, window(cfgw), slot_word(exp_r, cfgw));
            r_pend = 1'b0;
          end
        end
        if (chk && ch == 0 && b == 1) begin
          if (q.size() > 0) {exp_l, exp_r} = q.pop_front();
          else begin exp_l = '0; exp_r = '0; end
          exp_ok = 1'b1;
        end
        repeat (8) @(negedge clk);
      end
    end
  endtask

  task automatic do_reset(input logic wide);
    feed = 1'b0;
    rst_n = 1'b0;
    bclk = 1'b1;
    lrclk = 1'b1;
    slot_wide = wide;
    repeat (6) @(negedge clk);
    q.delete();
    exp_ok = 1'b0;
    r_pend = 1'b0;
    acc = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    do_reset(1'b0);
    check("R9 sdata after reset", 32'(sdata), 32'd0);
    check("R9 in_ready after reset", 32'(in_ready), 32'd1);
    check("R9 underrun after reset", 32'(underrun), 32'd0);
    check("R9 mismatch after reset", 32'(mismatch), 32'd0);

    feed = 1'b1;
    repeat (6) run_frame(16, 1'b1, 16);
    check("R6 in_ready low while a pair waits", 32'(in_ready), 32'd0);
    check("R8 no mismatch with 32xFs in narrow mode", 32'(mismatch), 32'd0);
    check("R7 no underrun while fed", 32'(underrun), 32'd0);

    do_reset(1'b1);
    feed = 1'b1;
    repeat (6) run_frame(32, 1'b1, 32);
    check("R8 no mismatch with 64xFs in wide mode", 32'(mismatch), 32'd0);
    check("R7 no underrun while fed wide", 32'(underrun), 32'd0);

    feed = 1'b0;
    run_frame(32, 1'b1, 32);
    check("R6 in_ready high once held pair consumed", 32'(in_ready), 32'd1);
    check("R7 underrun still clear", 32'(underrun), 32'd0);
    repeat (2) run_frame(32, 1'b1, 32);
    check("R7 underrun flag after silent frame", 32'(underrun), 32'd1);
    feed = 1'b1;
    repeat (4) run_frame(32, 1'b1, 32);
    check("R7 underrun stays set", 32'(underrun), 32'd1);

    do_reset(1'b0);
    feed = 1'b1;
    run_frame(16, 1'b1, 16);
    feed = 1'b0;
    repeat (3) run_frame(16, 1'b1, 16);
    check("R7 underrun in narrow mode", 32'(underrun), 32'd1);

    do_reset(1'b1);
    check("R9 underrun cleared by reset", 32'(underrun), 32'd0);
    repeat (3) run_frame(16, 1'b0, 32);
    check("R8 mismatch with 32xFs in wide mode", 32'(mismatch), 32'd1);

    do_reset(1'b0);
    check("R9 mismatch cleared by reset", 32'(mismatch), 32'd0);
    run_frame(16, 1'b0, 16);
    check("R8 first phase not judged", 32'(mismatch), 32'd0);
    repeat (2) run_frame(32, 1'b0, 16);
    check("R8 mismatch with 64xFs in narrow mode", 32'(mismatch), 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule